// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control core of a small register-based processor. It walks each instruction through its cycle (fetch, decode, evaluate address, fetch operands, execute, store result) and then fetches again. It owns the program counter, the memory address register, the memory buffer register, the instruction register and an effective-address register. It drives a memory port with separate read and write strobes that stay high until the memory answers with a ready flag, so a slow memory only stretches the phase that is waiting on it.

An outside decoder looks at the instruction word and returns an instruction class, a flag that says the result goes to memory, and a flag that says the instruction has a result at all. The sequencer samples these during its decode phase and leaves out the phases that class does not use. Address arithmetic, jump targets and results come from outside logic on dedicated inputs. The register file and the ALU are outside the block; the block only strobes them.

Fetch is broken into four register-transfer steps that always run in the same order. The PC is incremented before the fetched word arrives, so a control transfer that overwrites the PC during execute simply redirects the next fetch.

Top module: `cycle_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the PC to 0 and the phase to 0, with memRead, memWrite, opRead, exeGo and regWrite all low.
- R2: Phase codes are 0 fetch-address, 1 fetch-increment, 2 fetch-read, 3 fetch-load-IR, 4 decode, 5 evaluate-address, 6 fetch-operands, 7 execute, 8 store-result. Fetch always runs 0, 1, 2, 3, 4 in that order; the fetch read address equals the PC at the start of fetch, and the PC is one higher after phase 1.
- R3: A memory read holds memRead and memAddr steady until memReady is high; the read word is taken at that edge and the phase advances on the same edge. The fetched word appears on irOut when the phase reaches 4.
- R4: Class 0 (register operate) runs 4, 6, 7 and skips evaluate-address.
- R5: Class 2 (data move) runs 4, 6 and skips both evaluate-address and execute.
- R6: Class 3 (control transfer) loads the PC from targetIn during execute, and the next fetch reads from that address.
- R7: Class 1 (load/store) runs 4, 5, 6, 7; eaIn is captured in phase 5 and is the address of both the operand read and the result write. Its operand phase reads memory when dstIsMem is 0 and takes one cycle with opRead when dstIsMem is 1.
- R8: In store-result, dstIsMem 1 drives memWrite with memAddr at the effective address and memWdata equal to resultIn until memReady; dstIsMem 0 pulses regWrite for exactly one cycle.
- R9: An instruction whose hasResult flag is 0 skips store-result and goes from its last phase straight to phase 0.
- R10: Exactly one phase transition happens per clock edge; a phase with no memory wait lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instrClass | input | 2 | Decoded class: 0 operate, 1 load/store, 2 move, 3 control transfer |
| dstIsMem | input | 1 | Result goes to memory (also selects store form of load/store) |
| hasResult | input | 1 | Instruction writes a result |
| eaIn | input | AW | Effective address from address logic |
| targetIn | input | AW | New PC for control transfer |
| resultIn | input | DW | Result value to write |
| memReady | input | 1 | Memory has completed the current access |
| memRdata | input | DW | Memory read data |
| memAddr | output | AW | Memory address |
| memWdata | output | DW | Memory write data |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| opRead | output | 1 | Register operand read strobe |
| exeGo | output | 1 | Execute strobe to the ALU |
| regWrite | output | 1 | Register file write strobe |
| pcOut | output | AW | Program counter |
| irOut | output | DW | Instruction register |
| mdrOut | output | DW | Memory buffer register (loaded operand) |
| phase | output | 4 | Current phase code |

## Verification
Each non-waiting phase lasts one clock, and a memory phase lasts one clock plus the configured memory wait, so an instruction's full phase trace is predictable from its class, flags and wait count. The bench samples on the falling edge, records the phase of every cycle from one fetch to the next and compares that trace against one built from the requirements, then checks the values that a phase produces (IR at decode, MDR at execute, PC at the next fetch, memory contents after a write) one cycle after the edge that loads them. Memory waits of zero, one and two cycles are used so that held strobes and stable addresses are covered.

// File: rtl/cycle_seq_pkg.sv
package cycle_seq_pkg;

  typedef enum logic [3:0] {
    PH_FMAR = 4'd0,
    PH_FINC = 4'd1,
    PH_FMEM = 4'd2,
    PH_FIR  = 4'd3,
    PH_DEC  = 4'd4,
    PH_EVA  = 4'd5,
    PH_FOP  = 4'd6,
    PH_EXE  = 4'd7,
    PH_STR  = 4'd8
  } phase_t;

  typedef enum logic [1:0] {
    CLS_OPER = 2'd0,
    CLS_MEM  = 2'd1,
    CLS_MOVE = 2'd2,
    CLS_JUMP = 2'd3
  } iclass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic marLoad;
    logic pcInc;
    logic mdrLoad;
    logic irLoad;
    logic eaLoad;
    logic pcLoad;
    logic addrFromEa;
  } ctl_strobe_t;

endpackage

// File: rtl/cycle_seq_ctrl.sv
module cycle_seq_ctrl
  import cycle_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  instrClass,
  input  logic        dstIsMem,
  input  logic        hasResult,
  input  logic        memReady,
  output ctl_strobe_t strobe,
  output logic        memRead,
  output logic        memWrite,
  output logic        opRead,
  output logic        exeGo,
  output logic        regWrite,
  output logic [3:0]  phase
);

  phase_t  state, nextState;
  iclass_t clsQ;
  logic    dstQ, resQ;
  logic    loadOp;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PH_FMAR;
      clsQ  <= CLS_OPER;
      dstQ  <= 1'b0;
      resQ  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == PH_DEC) begin
        clsQ <= iclass_t'(instrClass);
        dstQ <= dstIsMem;
        resQ <= hasResult;
      end
    end
  end

  // operand phase touches memory only for the load form
  assign loadOp = (clsQ == CLS_MEM) && !dstQ;

  always_comb begin
    nextState = state;
    unique case (state)
      PH_FMAR: nextState = PH_FINC;
      PH_FINC: nextState = PH_FMEM;
      PH_FMEM: nextState = memReady ? PH_FIR : PH_FMEM;
      PH_FIR:  nextState = PH_DEC;
      PH_DEC:  nextState = (iclass_t'(instrClass) == CLS_MEM) ? PH_EVA : PH_FOP;
      PH_EVA:  nextState = PH_FOP;
      PH_FOP: begin
        if (loadOp && !memReady) nextState = PH_FOP;
        else if (clsQ == CLS_MOVE) nextState = resQ ? PH_STR : PH_FMAR;
        else nextState = PH_EXE;
      end
      PH_EXE:  nextState = resQ ? PH_STR : PH_FMAR;
      PH_STR:  nextState = (dstQ && !memReady) ? PH_STR : PH_FMAR;
      default: nextState = PH_FMAR;
    endcase
  end

  always_comb begin
    memRead  = (state == PH_FMEM) || (state == PH_FOP && loadOp);
    memWrite = (state == PH_STR) && dstQ;
    opRead   = (state == PH_FOP) && !loadOp;
    exeGo    = (state == PH_EXE);
    regWrite = (state == PH_STR) && !dstQ;

    strobe.marLoad    = (state == PH_FMAR);
    strobe.pcInc      = (state == PH_FINC);
    strobe.mdrLoad    = memRead && memReady;
    strobe.irLoad     = (state == PH_FIR);
    strobe.eaLoad     = (state == PH_EVA);
    strobe.pcLoad     = (state == PH_EXE) && (clsQ == CLS_JUMP);
    strobe.addrFromEa = (state == PH_FOP) || (state == PH_STR);
  end

  assign phase = state;

endmodule

// File: rtl/cycle_seq_dpath.sv
module cycle_seq_dpath
  import cycle_seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ctl_strobe_t   strobe,
  input  logic [AW-1:0] eaIn,
  input  logic [AW-1:0] targetIn,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] pcOut,
  output logic [DW-1:0] irOut,
  output logic [DW-1:0] mdrOut
);

  localparam logic [AW-1:0] PC_STEP = AW'(1);

  logic [AW-1:0] pcReg, marReg, eaReg;
  logic [DW-1:0] mdrReg, irReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg  <= '0;
      marReg <= '0;
      eaReg  <= '0;
      mdrReg <= '0;
      irReg  <= '0;
    end else begin
      if (strobe.marLoad) marReg <= pcReg;
      if (strobe.pcLoad) pcReg <= targetIn;
      else if (strobe.pcInc) pcReg <= pcReg + PC_STEP;
      if (strobe.mdrLoad) mdrReg <= memRdata;
      if (strobe.irLoad) irReg <= mdrReg;
      if (strobe.eaLoad) eaReg <= eaIn;
    end
  end

  assign memAddr = strobe.addrFromEa ? eaReg : marReg;
  assign pcOut   = pcReg;
  assign irOut   = irReg;
  assign mdrOut  = mdrReg;

endmodule

// File: rtl/cycle_seq.sv
module cycle_seq
  import cycle_seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    instrClass,
  input  logic          dstIsMem,
  input  logic          hasResult,
  input  logic [AW-1:0] eaIn,
  input  logic [AW-1:0] targetIn,
  input  logic [DW-1:0] resultIn,
  input  logic          memReady,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memRead,
  output logic          memWrite,
  output logic          opRead,
  output logic          exeGo,
  output logic          regWrite,
  output logic [AW-1:0] pcOut,
  output logic [DW-1:0] irOut,
  output logic [DW-1:0] mdrOut,
  output logic [3:0]    phase
);

  ctl_strobe_t strobe;

  cycle_seq_ctrl uCtrl (
    .clk        (clk),
    .rst        (rst),
    .instrClass (instrClass),
    .dstIsMem   (dstIsMem),
    .hasResult  (hasResult),
    .memReady   (memReady),
    .strobe     (strobe),
    .memRead    (memRead),
    .memWrite   (memWrite),
    .opRead     (opRead),
    .exeGo      (exeGo),
    .regWrite   (regWrite),
    .phase      (phase)
  );

  cycle_seq_dpath #(.AW(AW), .DW(DW)) uDpath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .eaIn     (eaIn),
    .targetIn (targetIn),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .pcOut    (pcOut),
    .irOut    (irOut),
    .mdrOut   (mdrOut)
  );

  assign memWdata = resultIn;

endmodule

// File: rtl/cycle_seq_checker.sv
module cycle_seq_checker #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    phase,
  input logic [AW-1:0] pcOut,
  input logic [AW-1:0] memAddr,
  input logic [DW-1:0] memWdata,
  input logic          memRead,
  input logic          memWrite,
  input logic          memReady,
  input logic          regWrite,
  input logic          exeGo
);

  // R1: reset state one edge after reset
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (phase == 4'd0 && pcOut == '0 && !memRead && !memWrite && !regWrite && !exeGo));

  // R2: the increment step adds one to the PC
  assert_pc_increment_R2: assert property (@(posedge clk) disable iff (rst)
    phase == 4'd1 |=> (pcOut == AW'($past(pcOut) + 1'b1) && phase == 4'd2));

  // R3: a waiting read keeps strobe and address
  assert_read_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (memRead && !memReady) |=> (memRead && $stable(memAddr)));

  // R8: a waiting write keeps strobe, address and data
  assert_write_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (memWrite && !memReady) |=> (memWrite && $stable(memAddr) && $stable(memWdata)));

  // R8: register write lasts a single cycle
  assert_regwrite_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    regWrite |=> !regWrite);

  // R10: single-cycle steps advance exactly one phase
  assert_ir_to_decode_R10: assert property (@(posedge clk) disable iff (rst)
    phase == 4'd3 |=> phase == 4'd4);

  assert_fetch_read_exit_R10: assert property (@(posedge clk) disable iff (rst)
    (phase == 4'd2 && memReady) |=> phase == 4'd3);

  // R3: read and write never overlap
  assert_no_rw_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));

endmodule

bind cycle_seq cycle_seq_checker #(.AW(AW), .DW(DW)) uChk (
  .clk      (clk),
  .rst      (rst),
  .phase    (phase),
  .pcOut    (pcOut),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .memRead  (memRead),
  .memWrite (memWrite),
  .memReady (memReady),
  .regWrite (regWrite),
  .exeGo    (exeGo)
);

// File: tb/tb_cycle_seq.sv
`timescale 1ns/1ps
module tb_cycle_seq;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    instrClass = 2'd0;
  logic          dstIsMem = 1'b0;
  logic          hasResult = 1'b0;
  logic [AW-1:0] eaIn = '0;
  logic [AW-1:0] targetIn = '0;
  logic [DW-1:0] resultIn = '0;
  logic          memReady;
  logic [DW-1:0] memRdata;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic          memRead, memWrite, opRead, exeGo, regWrite;
  logic [AW-1:0] pcOut;
  logic [DW-1:0] irOut, mdrOut;
  logic [3:0]    phase;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cycle_seq #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .instrClass(instrClass), .dstIsMem(dstIsMem),
    .hasResult(hasResult), .eaIn(eaIn), .targetIn(targetIn), .resultIn(resultIn),
    .memReady(memReady), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memRead(memRead), .memWrite(memWrite), .opRead(opRead), .exeGo(exeGo),
    .regWrite(regWrite), .pcOut(pcOut), .irOut(irOut), .mdrOut(mdrOut), .phase(phase)
  );

  // behavioural memory with a programmable wait
  logic [DW-1:0] mem [0:(1<<AW)-1];
  int lat = 0;
  int waitCnt = 0;

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 7 + 16'h1234);
  end

  assign memReady = (memRead || memWrite) && (waitCnt >= lat);
  assign memRdata = mem[memAddr];

  always @(posedge clk) begin
    if ((memRead || memWrite) && !memReady) waitCnt <= waitCnt + 1;
    else waitCnt <= 0;
    if (memWrite && memReady) mem[memAddr] <= memWdata;
  end

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // expected phase trace from the requirements
  function automatic logic [127:0] pushPh(input logic [127:0] s, input logic [3:0] p);
    return {s[123:0], p};
  endfunction

  function automatic logic [127:0] expTrace(input int cls, input logic dst, input logic res, input int w);
    logic [127:0] s = '0;
    s = pushPh(s, 4'd0); s = pushPh(s, 4'd1);
    for (int k = 0; k <= w; k++) s = pushPh(s, 4'd2);
    s = pushPh(s, 4'd3); s = pushPh(s, 4'd4);
    if (cls == 1) s = pushPh(s, 4'd5);
    if (cls == 1 && !dst) for (int k = 0; k <= w; k++) s = pushPh(s, 4'd6);
    else s = pushPh(s, 4'd6);
    if (cls != 2) s = pushPh(s, 4'd7);
    if (res) begin
      if (dst) for (int k = 0; k <= w; k++) s = pushPh(s, 4'd8);
      else s = pushPh(s, 4'd8);
    end
    return s;
  endfunction

  // observed values of one instruction
  logic [127:0]  gotTrace;
  logic [AW-1:0] fetchAddr, opAddr, wrAddr;
  logic [DW-1:0] irAtDec, mdrAtExe;
  int            regWrCnt;

  task automatic runInstr(input int cls, input logic dst, input logic res,
                          input logic [AW-1:0] ea, input logic [AW-1:0] tgt,
                          input logic [DW-1:0] rv, input int w);
    int n = 0;
    instrClass = 2'(cls); dstIsMem = dst; hasResult = res;
    eaIn = ea; targetIn = tgt; resultIn = rv; lat = w;
    gotTrace = '0; regWrCnt = 0;
    fetchAddr = '1; opAddr = '1; wrAddr = '1; irAtDec = '0; mdrAtExe = '0;
    do begin
      gotTrace = pushPh(gotTrace, phase);
      if (phase == 4'd2) fetchAddr = memAddr;
      if (phase == 4'd6 && memRead) opAddr = memAddr;
      if (memWrite) wrAddr = memAddr;
      if (phase == 4'd4) irAtDec = irOut;
      if (phase == 4'd7) mdrAtExe = mdrOut;
      if (regWrite) regWrCnt++;
      @(negedge clk);
      n++;
    end while (phase != 4'd0 && n < 40);
  endtask

  task automatic testReset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1", "phase", 32'(phase), 0);
    check("R1", "pc", 32'(pcOut), 0);
    check("R1", "strobes", {27'd0, memRead, memWrite, opRead, exeGo, regWrite}, 0);
  endtask

  task automatic testOperate();
    runInstr(0, 1'b0, 1'b1, 8'h00, 8'h00, 16'h0, 0);
    check("R4", "operate trace", gotTrace[31:0], expTrace(0, 1'b0, 1'b1, 0)[31:0]);
    check("R4", "operate trace hi", gotTrace[127:32], expTrace(0, 1'b0, 1'b1, 0)[127:32]);
    check("R2", "fetch address", 32'(fetchAddr), 0);
    check("R3", "ir at decode", 32'(irAtDec), 32'(mem[0]));
    check("R2", "pc after", 32'(pcOut), 1);
    check("R8", "register writes", regWrCnt, 1);
  endtask

  task automatic testLoad();
    runInstr(1, 1'b0, 1'b1, 8'h40, 8'h00, 16'h0, 2);
    check("R7", "load trace", gotTrace[63:0], expTrace(1, 1'b0, 1'b1, 2)[63:0]);
    check("R3", "fetch address under wait", 32'(fetchAddr), 1);
    check("R7", "operand read address", 32'(opAddr), 32'h40);
    check("R7", "loaded operand", 32'(mdrAtExe), 32'(mem[8'h40]));
    check("R8", "load register writes", regWrCnt, 1);
  endtask

  task automatic testStore();
    runInstr(1, 1'b1, 1'b1, 8'h50, 8'h00, 16'hBEEF, 1);
    check("R7", "store trace", gotTrace[63:0], expTrace(1, 1'b1, 1'b1, 1)[63:0]);
    check("R8", "write address", 32'(wrAddr), 32'h50);
    check("R8", "memory written", 32'(mem[8'h50]), 32'hBEEF);
    check("R8", "no register write", regWrCnt, 0);
    check("R7", "no operand read", 32'(opAddr), 32'hFF);
  endtask

  task automatic testMove();
    runInstr(2, 1'b0, 1'b1, 8'h00, 8'h00, 16'h0, 0);
    check("R5", "move trace", gotTrace[63:0], expTrace(2, 1'b0, 1'b1, 0)[63:0]);
    check("R5", "move fetch address", 32'(fetchAddr), 3);
  endtask

  task automatic testJump();
    runInstr(3, 1'b0, 1'b0, 8'h00, 8'h20, 16'h0, 0);
    check("R9", "jump trace", gotTrace[63:0], expTrace(3, 1'b0, 1'b0, 0)[63:0]);
    check("R6", "pc after jump", 32'(pcOut), 32'h20);
    check("R9", "no register write", regWrCnt, 0);
    runInstr(0, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0, 1);
    check("R6", "fetch from target", 32'(fetchAddr), 32'h20);
    check("R6", "ir from target", 32'(irAtDec), 32'(mem[8'h20]));
    check("R9", "no-result trace", gotTrace[63:0], expTrace(0, 1'b0, 1'b0, 1)[63:0]);
    check("R10", "pc after next", 32'(pcOut), 32'h21);
  endtask

  task automatic testMidReset();
    instrClass = 2'd1; dstIsMem = 1'b0; hasResult = 1'b1; lat = 3;
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "phase after mid reset", 32'(phase), 0);
    check("R1", "pc after mid reset", 32'(pcOut), 0);
    check("R1", "strobes after mid reset", {30'd0, memRead, memWrite}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog: got hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testOperate();
    testLoad();
    testStore();
    testMove();
    testJump();
    testMidReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule